// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable Baud

This block moves one 8-bit word across a serial peripheral link. It generates the serial clock, drives the master-out line and samples the master-in line, all from the low-speed peripheral clock. A start strobe loads the transmit word and takes a snapshot of the baud value, polarity and phase. The word is then shifted out MSB first while the received bits are shifted in. A busy flag covers the whole transfer, and a one-cycle done pulse marks the point where the received word becomes valid.

The serial clock period is set in whole peripheral cycles. Each bit period has two halves: a lead half and a trail half. For an odd divisor the half spent at the idle level is one peripheral cycle longer than the half spent away from it. This reproduces the asymmetric duty cycle of an odd division exactly. The phase input selects which half comes first. With phase 1 the idle half leads, so each output bit is presented before the clock leaves idle. With phase 0 the clock leaves idle as each bit starts. In both modes the master-in line is sampled at the edge between the lead half and the trail half.

Top module: `spi_baud_master`

## Requirements
- R1: For a baud value of 3 or more, each bit period lasts baud+1 peripheral clock cycles, and a transfer lasts 8 such periods.
- R2: For a baud value of 0, 1 or 2, each bit period lasts exactly 4 peripheral clock cycles.
- R3: Within a bit period, the half at the idle level lasts ceil(P/2) cycles and the half away from it lasts floor(P/2) cycles, where P is the period. For an odd P, polarity 0 therefore gives a high time one cycle shorter than the low time, and polarity 1 gives a low time one cycle shorter than the high time.
- R4: With phase 1, each bit period begins with the idle-level half and then moves to the non-idle level. The master-in line is sampled on the last peripheral cycle of the first half.
- R5: With phase 0, each bit period begins with the non-idle half and then returns to the idle level. The master-in line is sampled on the last peripheral cycle of the first half.
- R6: The master-out line carries transmit bit 7-b for the whole of bit period b. Bit 0 of the received word is the last bit sampled.
- R7: Busy rises in the cycle after the accepted start strobe and stays high for exactly 8 bit periods.
- R8: Done is high for exactly one cycle: the first cycle after busy falls. The received word is valid in that cycle.
- R9: While no transfer is running, the serial clock rests at the polarity level, which is 0 for idle-low and 1 for idle-high.
- R10: A start strobe during busy is ignored. Changes to the transmit word, baud value or polarity during busy have no effect on the transfer in progress.
- R11: A start strobe in the done cycle is accepted, and the next transfer begins without a gap.
- R12: After reset, the serial clock, master-out line, busy, done and received word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| tx_word_i | input | DATA_W | Word to transmit |
| baud_i | input | BAUD_W | Baud value that sets the serial clock period |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 1 = idle half leads each bit, 0 = non-idle half leads |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| rx_word_o | output | DATA_W | Last received word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The done pulse and the acceptance of a new start strobe can fall in the same cycle. The same holds for the last bit's completion and a strobe that arrives while busy. The bench raises start in the done cycle for about half of the sweep points and checks two things: the received word of the finished transfer, and the serial clock lead level and MSB of the new transfer in the very next cycle. Mid-transfer strobes are sent together with a changed word, baud value and polarity, and every later cycle of the running transfer must still match the snapshot taken at its start.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spim_state_e;

    typedef enum logic {
        HALF_LEAD  = 1'b0,
        HALF_TRAIL = 1'b1
    } spim_half_e;

endpackage

// File: rtl/spim_timing.sv
module spim_timing #(
    parameter int BAUD_W = 7,
    localparam int HALF_W = BAUD_W
) (
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    output logic [HALF_W-1:0] len_lead_o,
    output logic [HALF_W-1:0] len_trail_o,
    output logic              lvl_lead_o
);

    localparam int MIN_BAUD  = 3;
    localparam int FLOOR_DIV = 4;

    logic [BAUD_W:0]   divisor;
    logic [HALF_W-1:0] short_len;
    logic [HALF_W-1:0] long_len;

    always_comb begin
        if (baud_i < BAUD_W'(MIN_BAUD)) begin
            divisor = (BAUD_W+1)'(FLOOR_DIV);
        end else begin
            divisor = {1'b0, baud_i} + (BAUD_W+1)'(1);
        end
        // active-level half gets floor, idle-level half gets ceil
        short_len = divisor[BAUD_W:1];
        long_len  = divisor[BAUD_W:1] + HALF_W'(divisor[0]);
    end

    always_comb begin
        if (cpha_i) begin
            len_lead_o  = long_len;
            len_trail_o = short_len;
            lvl_lead_o  = cpol_i;
        end else begin
            len_lead_o  = short_len;
            len_trail_o = long_len;
            lvl_lead_o  = ~cpol_i;
        end
    end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_word_i,
    input  logic              advance_i,
    input  logic              sample_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_shift_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = load_word_i;
        end else if (advance_i) begin
            sh_d.tx = {sh_q.tx[DATA_W-2:0], 1'b0};
        end
        if (sample_i) begin
            sh_d.rx = {sh_q.rx[DATA_W-2:0], miso_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi_o     = sh_q.tx[DATA_W-1];
    assign rx_shift_o = sh_q.rx;

endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master #(
    parameter int DATA_W = 8,
    parameter int BAUD_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_word_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              busy_o,
    output logic              done_o
);
    import spim_pkg::*;

    localparam int HALF_W = BAUD_W;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W-1);

    typedef struct packed {
        logic [HALF_W-1:0] len_lead;
        logic [HALF_W-1:0] len_trail;
        logic              lvl_lead;
        logic              idle_lvl;
    } cfg_t;

    typedef struct packed {
        spim_state_e       state;
        spim_half_e        half;
        logic [HALF_W-1:0] cnt;
        logic [BIT_W-1:0]  bitn;
        logic              sclk;
        logic              busy;
        logic              done;
        logic [DATA_W-1:0] rx_word;
        cfg_t              cfg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [HALF_W-1:0] len_lead, len_trail;
    logic              lvl_lead;
    logic              sh_load, sh_adv, sh_smp;
    logic [DATA_W-1:0] rx_shift;
    logic              mosi_w;

    spim_timing #(.BAUD_W(BAUD_W)) i_timing (
        .baud_i      (baud_i),
        .cpol_i      (cpol_i),
        .cpha_i      (cpha_i),
        .len_lead_o  (len_lead),
        .len_trail_o (len_trail),
        .lvl_lead_o  (lvl_lead)
    );

    spim_shift #(.DATA_W(DATA_W)) i_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (sh_load),
        .load_word_i (tx_word_i),
        .advance_i   (sh_adv),
        .sample_i    (sh_smp),
        .miso_i      (miso_i),
        .mosi_o      (mosi_w),
        .rx_shift_o  (rx_shift)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        sh_load    = 1'b0;
        sh_adv     = 1'b0;
        sh_smp     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.sclk = cpol_i;
                if (start_i) begin
                    ctl_d.state         = ST_RUN;
                    ctl_d.busy          = 1'b1;
                    ctl_d.cfg.len_lead  = len_lead;
                    ctl_d.cfg.len_trail = len_trail;
                    ctl_d.cfg.lvl_lead  = lvl_lead;
                    ctl_d.cfg.idle_lvl  = cpol_i;
                    ctl_d.half          = HALF_LEAD;
                    ctl_d.cnt           = len_lead - HALF_W'(1);
                    ctl_d.bitn          = '0;
                    ctl_d.sclk          = lvl_lead;
                    sh_load             = 1'b1;
                end
            end
            ST_RUN: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - HALF_W'(1);
                end else if (ctl_q.half == HALF_LEAD) begin
                    sh_smp     = 1'b1;
                    ctl_d.half = HALF_TRAIL;
                    ctl_d.cnt  = ctl_q.cfg.len_trail - HALF_W'(1);
                    ctl_d.sclk = ~ctl_q.cfg.lvl_lead;
                end else if (ctl_q.bitn == LAST_BIT) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.busy    = 1'b0;
                    ctl_d.done    = 1'b1;
                    ctl_d.sclk    = ctl_q.cfg.idle_lvl;
                    ctl_d.rx_word = rx_shift;
                end else begin
                    sh_adv     = 1'b1;
                    ctl_d.bitn = ctl_q.bitn + BIT_W'(1);
                    ctl_d.half = HALF_LEAD;
                    ctl_d.cnt  = ctl_q.cfg.len_lead - HALF_W'(1);
                    ctl_d.sclk = ctl_q.cfg.lvl_lead;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk_o    = ctl_q.sclk;
    assign mosi_o    = mosi_w;
    assign rx_word_o = ctl_q.rx_word;
    assign busy_o    = ctl_q.busy;
    assign done_o    = ctl_q.done;

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.done |=> !ctl_q.done);

    // R7
    busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ctl_q.busy) |-> ctl_q.done);

    // R10
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.busy && start_i) |=> (ctl_q.busy || ctl_q.done));

    // R3
    sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.busy && ctl_q.cnt != '0) |=> $stable(sclk_o));

    // R6
    mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.busy && !(ctl_q.cnt == '0 && ctl_q.half == HALF_TRAIL)) |=> $stable(mosi_o));

endmodule

// File: tb/test_spi_baud_master.sv
module test_spi_baud_master;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int BW = 7;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] tx_word_i = '0;
    logic [BW-1:0] baud_i = '0;
    logic          cpol_i = 1'b0;
    logic          cpha_i = 1'b0;
    logic          miso_i = 1'b0;
    logic          sclk_o, mosi_o, busy_o, done_o;
    logic [DW-1:0] rx_word_o;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    spi_baud_master #(.DATA_W(DW), .BAUD_W(BW)) i_spi_baud_master (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .tx_word_i (tx_word_i),
        .baud_i    (baud_i),
        .cpol_i    (cpol_i),
        .cpha_i    (cpha_i),
        .miso_i    (miso_i),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .rx_word_o (rx_word_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int period_of(input int baud);
        return (baud < 3) ? 4 : baud + 1;
    endfunction

    task automatic idle_chk(input int n, input bit pol);
        start_i = 1'b0;
        repeat (n) begin
            @(negedge clk_i);
            chk(sclk_o == pol, "R9 idle sclk", int'(sclk_o), int'(pol));
            chk(done_o == 1'b0, "R8 done low", int'(done_o), 0);
            chk(busy_o == 1'b0, "R7 busy low", int'(busy_o), 0);
        end
    endtask

    // called at a negedge; returns at the negedge of the done cycle
    task automatic xfer(input int baud, input bit pol, input bit pha,
                        input logic [DW-1:0] tx, input logic [DW-1:0] pat,
                        input bit ign, input bit b2b);
        int  div;
        int  len_lead;
        bit  lvl_lead;
        string stag;
        div      = period_of(baud);
        len_lead = pha ? (div - div/2) : (div/2);
        lvl_lead = pha ? pol : ~pol;
        stag = $sformatf("%s%s/%s sclk", (div % 2 == 1) ? "R3/" : "",
                         (baud < 3) ? "R2" : "R1", pha ? "R4" : "R5");
        baud_i    = BW'(baud);
        cpol_i    = pol;
        cpha_i    = pha;
        tx_word_i = tx;
        start_i   = 1'b1;
        @(posedge clk_i);
        for (int k = 0; k < DW*div; k++) begin
            int p;
            int b;
            bit exp_sclk;
            p = k % div;
            b = k / div;
            @(negedge clk_i);
            start_i = 1'b0;
            if (ign && k == div + 1) begin
                start_i   = 1'b1;
                tx_word_i = ~tx;
                baud_i    = BW'(baud) ^ BW'(5);
                cpol_i    = ~pol;
            end
            if (ign && k == div + 2) begin
                tx_word_i = tx;
                baud_i    = BW'(baud);
                cpol_i    = pol;
            end
            exp_sclk = (p < len_lead) ? lvl_lead : ~lvl_lead;
            chk(sclk_o == exp_sclk, ign ? {"R10 ", stag} : stag, int'(sclk_o), int'(exp_sclk));
            chk(mosi_o == tx[DW-1-b], ign ? "R10 R6 mosi" : "R6 mosi", int'(mosi_o), int'(tx[DW-1-b]));
            chk(busy_o == 1'b1, (b2b && k == 0) ? "R11 busy" : "R7 busy", int'(busy_o), 1);
            miso_i = (p == len_lead - 1) ? pat[DW-1-b] : ~pat[DW-1-b];
        end
        @(negedge clk_i);
        chk(busy_o == 1'b0, "R7 busy end", int'(busy_o), 0);
        chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
        chk(sclk_o == pol, "R9 sclk at done", int'(sclk_o), int'(pol));
        chk(rx_word_o == pat, ign ? "R10 rx" : (pha ? "R4 R6 rx" : "R5 R6 rx"),
            int'(rx_word_o), int'(pat));
    endtask

    initial begin
        bit gap_prev;
        @(negedge clk_i);
        @(negedge clk_i);
        chk(sclk_o == 1'b0, "R12 sclk", int'(sclk_o), 0);
        chk(mosi_o == 1'b0, "R12 mosi", int'(mosi_o), 0);
        chk(busy_o == 1'b0, "R12 busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R12 done", int'(done_o), 0);
        chk(rx_word_o == '0, "R12 rx", int'(rx_word_o), 0);
        rst_ni = 1'b1;
        idle_chk(2, 1'b0);
        gap_prev = 1'b1;
        for (int baud = 0; baud <= 12; baud++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int pha = 0; pha < 2; pha++) begin
                    logic [DW-1:0] tx;
                    logic [DW-1:0] pat;
                    bit gap;
                    tx  = DW'(baud*37 + pol*5 + pha*11 + 8'h5A);
                    pat = ~tx ^ DW'(8'h33 + baud);
                    gap = ((baud + pol + pha) % 2) == 0;
                    xfer(baud, pol[0], pha[0], tx, pat, (baud % 3) == 0, !gap_prev);
                    if (gap) begin
                        cpol_i = pol[0];
                        idle_chk(2, pol[0]);
                    end
                    gap_prev = gap;
                end
            end
        end
        for (int m = 0; m < 4; m++) begin
            xfer(127, m[0], m[1], DW'(8'hC3 ^ m), DW'(8'h96 + m), m == 2, m != 0);
        end
        idle_chk(2, 1'b1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule